// File: doc/BRIEF.md
# Six-Point Stencil Read Address Sequencer

This block produces the read address stream for a three-dimensional six-point stencil. The grid is X by Y by Z elements, stored linearly with the Z index varying fastest. The sweep covers every interior point: i runs over 1..X-2, j over 1..Y-2 and k over 1..Z-2, with k innermost. Each point has six neighbours. Every address leaves the block with a tag from 0 to 5, so that downstream logic can steer the returned word into one of six per-neighbour queues.

There are two request orders. In point-major order, the six neighbour addresses of one point are issued together before the next point starts. In blocked order, a window of up to `block_len` consecutive points is swept once for each neighbour tag in turn. The next window starts after tag 5. A window of one point gives the point-major sequence. The last window of a sweep may be shorter than `block_len`.

A one-cycle `start` in the idle state captures the configuration. The controller has three states. GEN_IDLE waits for start. GEN_ISSUE holds `addr_valid` high until the final address is accepted. GEN_FINISH raises `done` for one cycle and returns to GEN_IDLE. The transitions are named as follows:
- IDLE→ISSUE on start with a non-empty interior.
- IDLE→FINISH on start with an empty interior.
- ISSUE→ISSUE on each accept that is not the last one.
- ISSUE→FINISH on the last accept.
- FINISH→IDLE unconditionally.

Top module: `stencil_addr_gen`

## Requirements
- R1: After reset `addr_valid` and `done` are low.
- R2: With `array_mode`=0, each interior point (k fastest, then j, then i) issues tags 0,1,2,3,4,5 in that order before the next point begins.
- R3: The address for tag t of point (i,j,k) is `base_addr` + 8*((i'*Y + j')*Z + k'). The neighbour (i',j',k') is selected by tag: 0:(i-1,j,k), 1:(i+1,j,k), 2:(i,j-1,k), 3:(i,j+1,k), 4:(i,j,k-1), 5:(i,j,k+1).
- R4: With `array_mode`=1, tag t is issued for every point of the current window, in point order, before tag t+1. After tag 5 the next window begins at the following point.
- R5: In blocked order, a `block_len` of 1 gives exactly the point-major sequence, and a `block_len` of 0 is treated as 1.
- R6: A final window shorter than `block_len`, or a `block_len` larger than the whole sweep, covers only the remaining interior points and never issues an address outside the interior sweep.
- R7: While `addr_valid` is high and `addr_ready` is low, `addr_valid`, `addr_out` and `stream_tag` hold their values. An address counts as consumed only on a cycle with both high.
- R8: `done` is high for exactly one cycle, the cycle after the last address is accepted, and `addr_valid` is low in that cycle.
- R9: `start` and the configuration inputs are ignored while a sweep is in progress.
- R10: If any dimension is below 3, a start produces no address, and `done` pulses in the cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep (sampled only when idle) |
| array_mode | input | 1 | 0 point-major order, 1 blocked order |
| dim_x | input | DIM_W | Grid extent X |
| dim_y | input | DIM_W | Grid extent Y |
| dim_z | input | DIM_W | Grid extent Z (fastest index) |
| base_addr | input | ADDR_W | Byte address of element (0,0,0) |
| block_len | input | BLK_W | Points per window in blocked order |
| addr_valid | output | 1 | Address available |
| addr_ready | input | 1 | Consumer takes the address |
| addr_out | output | ADDR_W | Byte read address |
| stream_tag | output | 3 | Neighbour tag 0..5 |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The hardest situation to reach is a window that ends inside a row or plane boundary. This forces the cursor to rewind across a carry in j or i, and it interacts with a short final window. The stimulus sweeps every `block_len` from 0 to 9 over a grid of eight interior points with a 2-deep k row. This places window edges at every offset relative to the row wrap. Other cases add a block length that divides the sweep exactly, one that exceeds it, a start pulse with altered configuration during a stalled transfer, and an irregular ready pattern. Every accepted address is compared with a sequence the bench computes from the loop nest.

// File: rtl/stencil_pkg.sv
package stencil_pkg;

    localparam int NUM_TAGS = 6;

    typedef logic [2:0] tag_t;

    typedef enum logic [1:0] {
        GEN_IDLE,
        GEN_ISSUE,
        GEN_FINISH
    } gen_state_t;

    typedef enum logic [2:0] {
        CUR_HOLD,
        CUR_FIRST,
        CUR_STEP,
        CUR_STEP_MARK,
        CUR_RESTORE
    } cur_op_t;

endpackage

// File: rtl/stencil_cursor.sv
module stencil_cursor
    import stencil_pkg::*;
#(
    parameter int DIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cur_op_t          op,
    input  logic [DIM_W-1:0] i_max,
    input  logic [DIM_W-1:0] j_max,
    input  logic [DIM_W-1:0] k_max,
    output logic [DIM_W-1:0] pos_i,
    output logic [DIM_W-1:0] pos_j,
    output logic [DIM_W-1:0] pos_k,
    output logic             at_last
);

    localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

    logic [DIM_W-1:0] cur_i, cur_j, cur_k;
    logic [DIM_W-1:0] mark_i, mark_j, mark_k;
    logic [DIM_W-1:0] nxt_i, nxt_j, nxt_k;
    logic             wrap_k, wrap_j;

    always_comb begin
        wrap_k = (cur_k == k_max);
        wrap_j = (cur_j == j_max);
        nxt_k  = wrap_k ? ONE : cur_k + ONE;
        nxt_j  = wrap_k ? (wrap_j ? ONE : cur_j + ONE) : cur_j;
        nxt_i  = (wrap_k && wrap_j) ? cur_i + ONE : cur_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_i  <= '0;
            cur_j  <= '0;
            cur_k  <= '0;
            mark_i <= '0;
            mark_j <= '0;
            mark_k <= '0;
        end else begin
            unique case (op)
                CUR_FIRST: begin
                    cur_i  <= ONE;
                    cur_j  <= ONE;
                    cur_k  <= ONE;
                    mark_i <= ONE;
                    mark_j <= ONE;
                    mark_k <= ONE;
                end
                CUR_STEP: begin
                    cur_i <= nxt_i;
                    cur_j <= nxt_j;
                    cur_k <= nxt_k;
                end
                CUR_STEP_MARK: begin
                    cur_i  <= nxt_i;
                    cur_j  <= nxt_j;
                    cur_k  <= nxt_k;
                    mark_i <= nxt_i;
                    mark_j <= nxt_j;
                    mark_k <= nxt_k;
                end
                CUR_RESTORE: begin
                    cur_i <= mark_i;
                    cur_j <= mark_j;
                    cur_k <= mark_k;
                end
                default: ;
            endcase
        end
    end

    assign pos_i   = cur_i;
    assign pos_j   = cur_j;
    assign pos_k   = cur_k;
    assign at_last = (cur_i == i_max) && (cur_j == j_max) && (cur_k == k_max);

    // R6: the controller never asks to step past the final interior point
    assert_no_step_past_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CUR_STEP || op == CUR_STEP_MARK) |-> !at_last);

    // R6: a step keeps the cursor inside the interior box
    assert_step_in_box_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CUR_STEP) |=> (cur_i >= ONE && cur_i <= i_max &&
                              cur_j >= ONE && cur_j <= j_max &&
                              cur_k >= ONE && cur_k <= k_max));

endmodule

// File: rtl/stencil_addr.sv
module stencil_addr
    import stencil_pkg::*;
#(
    parameter int DIM_W      = 8,
    parameter int ADDR_W     = 32,
    parameter int ELEM_SHIFT = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DIM_W-1:0]  ext_y,
    input  logic [DIM_W-1:0]  ext_z,
    input  logic [DIM_W-1:0]  pos_i,
    input  logic [DIM_W-1:0]  pos_j,
    input  logic [DIM_W-1:0]  pos_k,
    input  tag_t              tag,
    output logic [ADDR_W-1:0] addr
);

    localparam int LIN_W = 3 * DIM_W;

    logic [DIM_W-1:0]  nb_i, nb_j, nb_k;
    logic [LIN_W-1:0]  plane, row, lin;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        nb_i = pos_i;
        nb_j = pos_j;
        nb_k = pos_k;
        case (tag)
            3'd0:    nb_i = pos_i - DIM_W'(1);
            3'd1:    nb_i = pos_i + DIM_W'(1);
            3'd2:    nb_j = pos_j - DIM_W'(1);
            3'd3:    nb_j = pos_j + DIM_W'(1);
            3'd4:    nb_k = pos_k - DIM_W'(1);
            3'd5:    nb_k = pos_k + DIM_W'(1);
            default: ;
        endcase
        plane  = LIN_W'(nb_i) * LIN_W'(ext_y) + LIN_W'(nb_j);
        row    = plane * LIN_W'(ext_z);
        lin    = row + LIN_W'(nb_k);
        offset = ADDR_W'(lin) << ELEM_SHIFT;
        addr   = base + offset;
    end

endmodule

// File: rtl/stencil_addr_gen.sv
module stencil_addr_gen
    import stencil_pkg::*;
#(
    parameter int DIM_W      = 8,
    parameter int ADDR_W     = 32,
    parameter int BLK_W      = 8,
    parameter int ELEM_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              array_mode,
    input  logic [DIM_W-1:0]  dim_x,
    input  logic [DIM_W-1:0]  dim_y,
    input  logic [DIM_W-1:0]  dim_z,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [BLK_W-1:0]  block_len,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [ADDR_W-1:0] addr_out,
    output logic [2:0]        stream_tag,
    output logic              done
);

    localparam int   ELEM_SHIFT = $clog2(ELEM_BYTES);
    localparam tag_t LAST_TAG   = tag_t'(NUM_TAGS - 1);

    gen_state_t        state_q, state_d;
    cur_op_t           cur_op;
    tag_t              tag_q, tag_d;
    logic [BLK_W-1:0]  cnt_q, cnt_d;

    logic [ADDR_W-1:0] cfg_base;
    logic [DIM_W-1:0]  cfg_y, cfg_z;
    logic [DIM_W-1:0]  lim_i, lim_j, lim_k;
    logic [BLK_W-1:0]  cfg_blk;
    logic              cfg_array;

    logic [DIM_W-1:0]  pos_i, pos_j, pos_k;
    logic              at_last;
    logic              empty_box;
    logic              win_end;
    logic              accept;

    assign empty_box = (dim_x < DIM_W'(3)) || (dim_y < DIM_W'(3)) || (dim_z < DIM_W'(3));
    assign accept    = (state_q == GEN_ISSUE) && addr_ready;
    assign win_end   = at_last || (({1'b0, cnt_q} + 1'b1) == {1'b0, cfg_blk});

    // configuration capture, only when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_base  <= '0;
            cfg_y     <= '0;
            cfg_z     <= '0;
            lim_i     <= '0;
            lim_j     <= '0;
            lim_k     <= '0;
            cfg_blk   <= BLK_W'(1);
            cfg_array <= 1'b0;
        end else if (state_q == GEN_IDLE && start) begin
            cfg_base  <= base_addr;
            cfg_y     <= dim_y;
            cfg_z     <= dim_z;
            lim_i     <= dim_x - DIM_W'(2);
            lim_j     <= dim_y - DIM_W'(2);
            lim_k     <= dim_z - DIM_W'(2);
            cfg_array <= array_mode;
            if (array_mode && block_len != '0)
                cfg_blk <= block_len;
            else
                cfg_blk <= BLK_W'(1);
        end
    end

    // next-state and cursor control
    always_comb begin
        state_d = state_q;
        cur_op  = CUR_HOLD;
        tag_d   = tag_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            GEN_IDLE: begin
                if (start) begin
                    cur_op  = CUR_FIRST;
                    tag_d   = '0;
                    cnt_d   = '0;
                    state_d = empty_box ? GEN_FINISH : GEN_ISSUE;
                end
            end
            GEN_ISSUE: begin
                if (addr_ready) begin
                    if (!win_end) begin
                        cur_op = CUR_STEP;
                        cnt_d  = cnt_q + BLK_W'(1);
                    end else if (tag_q != LAST_TAG) begin
                        cur_op = CUR_RESTORE;
                        tag_d  = tag_q + tag_t'(1);
                        cnt_d  = '0;
                    end else if (at_last) begin
                        state_d = GEN_FINISH;
                    end else begin
                        cur_op = CUR_STEP_MARK;
                        tag_d  = '0;
                        cnt_d  = '0;
                    end
                end
            end
            GEN_FINISH: state_d = GEN_IDLE;
            default:    state_d = GEN_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GEN_IDLE;
        else        state_q <= state_d;
    end

    // tag and window counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            cnt_q <= '0;
        end else begin
            tag_q <= tag_d;
            cnt_q <= cnt_d;
        end
    end

    stencil_cursor #(.DIM_W(DIM_W)) u_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (cur_op),
        .i_max   (lim_i),
        .j_max   (lim_j),
        .k_max   (lim_k),
        .pos_i   (pos_i),
        .pos_j   (pos_j),
        .pos_k   (pos_k),
        .at_last (at_last)
    );

    stencil_addr #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .ELEM_SHIFT(ELEM_SHIFT)) u_addr (
        .base  (cfg_base),
        .ext_y (cfg_y),
        .ext_z (cfg_z),
        .pos_i (pos_i),
        .pos_j (pos_j),
        .pos_k (pos_k),
        .tag   (tag_q),
        .addr  (addr_out)
    );

    // outputs
    always_comb begin
        addr_valid = (state_q == GEN_ISSUE);
        done       = (state_q == GEN_FINISH);
        stream_tag = tag_q;
    end

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_out) && $stable(stream_tag)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) && $past(addr_valid) |-> $past(addr_ready));

    assert_point_major_tags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_array && accept && stream_tag != 3'd5) |=> (stream_tag == $past(stream_tag) + 3'd1));

    assert_tag_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (stream_tag <= 3'd5));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready && start) |=> (addr_valid && $stable(addr_out)));

    assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (addr_out[ELEM_SHIFT-1:0] == cfg_base[ELEM_SHIFT-1:0]));

endmodule

// File: tb/test_stencil_addr_gen.sv
module test_stencil_addr_gen;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_EXP    = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        array_mode = 1'b0;
    logic [7:0]  dim_x = '0, dim_y = '0, dim_z = '0;
    logic [31:0] base_addr = '0;
    logic [7:0]  block_len = '0;
    logic        addr_valid;
    logic        addr_ready = 1'b0;
    logic [31:0] addr_out;
    logic [2:0]  stream_tag;
    logic        done;

    int n_checks = 0;
    int n_errors = 0;

    logic [31:0] exp_a [MAX_EXP];
    int          exp_t [MAX_EXP];

    always #(CLK_PERIOD/2) clk = ~clk;

    stencil_addr_gen i_stencil_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .array_mode(array_mode),
        .dim_x(dim_x), .dim_y(dim_y), .dim_z(dim_z), .base_addr(base_addr),
        .block_len(block_len), .addr_valid(addr_valid), .addr_ready(addr_ready),
        .addr_out(addr_out), .stream_tag(stream_tag), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] nb_addr(int i, int j, int k, int t, int y, int z, logic [31:0] b);
        int ii = i, jj = j, kk = k;
        case (t)
            0: ii = i - 1;
            1: ii = i + 1;
            2: jj = j - 1;
            3: jj = j + 1;
            4: kk = k - 1;
            default: kk = k + 1;
        endcase
        return b + 32'(((ii * y + jj) * z + kk) * 8);
    endfunction

    // R2 R4 R5 R6: expected order built from the loop nest
    function automatic int build_exp(int x, int y, int z, bit am, int bl, logic [31:0] b);
        int cnt = 0;
        int ni = x - 2, nj = y - 2, nk = z - 2;
        int npts, win;
        if (x < 3 || y < 3 || z < 3) return 0;
        npts = ni * nj * nk;
        win  = (am && bl != 0) ? bl : 1;
        for (int s0 = 0; s0 < npts; s0 += win)
            for (int t = 0; t < 6; t++)
                for (int n = s0; n < s0 + win && n < npts; n++) begin
                    int k = n % nk + 1;
                    int j = (n / nk) % nj + 1;
                    int i = n / (nk * nj) + 1;
                    exp_a[cnt] = nb_addr(i, j, k, t, y, z, b);
                    exp_t[cnt] = t;
                    cnt++;
                end
        return cnt;
    endfunction

    task automatic run_case(input int x, input int y, input int z, input bit am, input int bl,
                            input int stall, input bit poke, input string tagname);
        int total, idx, cyc;
        bit held;
        logic [31:0] held_a;
        logic [2:0]  held_t;
        logic [31:0] b = 32'h0010_0000 + 32'(x * 256);
        total = build_exp(x, y, z, am, bl, b);
        @(negedge clk);
        dim_x = 8'(x); dim_y = 8'(y); dim_z = 8'(z);
        array_mode = am; block_len = 8'(bl); base_addr = b;
        addr_ready = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idx = 0; cyc = 0; held = 0;
        while (idx < total && cyc < 4000) begin
            addr_ready = (stall == 0) ? 1'b1 : ((cyc % 3) != 2 && (cyc % 7) != 4);
            if (poke && cyc == 4) begin
                addr_ready = 1'b0;
                start = 1'b1; dim_x = 8'd9; dim_z = 8'd2; block_len = 8'd3; base_addr = 32'hDEAD_0000;
                array_mode = ~am;
            end else begin
                start = 1'b0;
            end
            #1;
            if (held) begin
                // R7 R9: stalled output must not move
                check(addr_valid === 1'b1 && addr_out === held_a && stream_tag === held_t,
                      {tagname, " R7 hold"}, {addr_out, 5'd0, stream_tag}, {held_a, 5'd0, held_t});
            end
            if (done === 1'b1) check(0, {tagname, " R8 early done"}, idx, total);
            if (addr_valid !== 1'b1) begin
                check(0, {tagname, " R2 valid dropped"}, idx, total);
                break;
            end
            if (addr_ready) begin
                check(addr_out === exp_a[idx] && int'(stream_tag) == exp_t[idx],
                      $sformatf("%s R3 R4 item %0d", tagname, idx),
                      {addr_out, 5'd0, stream_tag}, {exp_a[idx], 5'd0, 3'(exp_t[idx])});
                idx++;
                held = 0;
            end else begin
                held = 1; held_a = addr_out; held_t = stream_tag;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        addr_ready = 1'b0;
        if (cyc >= 4000) check(0, {tagname, " watchdog"}, cyc, total);
        // R8 R10: done one cycle after last accept (or after start when empty)
        check(done === 1'b1 && addr_valid === 1'b0, {tagname, " R8 R10 done pulse"}, {done, addr_valid}, 2'b10);
        @(negedge clk);
        check(done === 1'b0 && addr_valid === 1'b0, {tagname, " R8 done one cycle"}, {done, addr_valid}, 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(addr_valid === 1'b0 && done === 1'b0, "R1 reset outputs", {addr_valid, done}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check(addr_valid === 1'b0 && done === 1'b0, "R1 idle after reset", {addr_valid, done}, 2'b00);

        run_case(4, 5, 5, 1'b0, 0, 0, 1'b0, "R2 point-major");
        run_case(5, 4, 6, 1'b0, 7, 1, 1'b0, "R2 R7 point-major stalled");
        run_case(4, 5, 5, 1'b1, 4, 0, 1'b0, "R4 R6 blocked partial");
        run_case(4, 5, 5, 1'b1, 18, 0, 1'b0, "R6 blocked exact");
        run_case(4, 5, 5, 1'b1, 25, 1, 1'b0, "R6 blocked oversize");
        run_case(4, 5, 5, 1'b1, 1, 0, 1'b0, "R5 blocked one");
        run_case(4, 5, 5, 1'b1, 0, 0, 1'b0, "R5 blocked zero");
        run_case(3, 3, 7, 1'b1, 2, 1, 1'b1, "R9 start during run");
        run_case(2, 5, 5, 1'b1, 4, 0, 1'b0, "R10 empty x");
        run_case(5, 5, 1, 1'b0, 0, 0, 1'b0, "R10 empty z");
        // near-exhaustive window sweep: 2x2x2 interior points
        for (int bl = 0; bl < 10; bl++)
            run_case(4, 4, 4, 1'b1, bl, bl % 2, 1'b0, $sformatf("R4 R6 sweep bl=%0d", bl));
        for (int bl = 0; bl < 4; bl++)
            run_case(3, 4, 6, 1'b1, bl + 3, 1, 1'b0, $sformatf("R6 row sweep bl=%0d", bl + 3));

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule